// File: doc/BRIEF.md
# I2S Slave Audio Transmitter

This block sends 16-bit stereo samples on a serial data line. The bit clock and the word-select line both come from an external master. The block never drives a clock. Both inputs pass through synchronisers into the system clock domain. Bit-clock edges are then found from the synchronised samples, so the system clock must run at least four times faster than the bit clock. Framing follows the Philips I2S convention:

- Word-select low marks the left channel and word-select high marks the right channel.
- A word-select change marks a channel boundary.
- The word's most significant bit goes out one bit period after that boundary.
- Serial data changes after bit-clock falling edges.

A host feeds a one-entry holding buffer, starting with the left sample and then alternating. At the first bit of each word, the buffer is copied into a shift register and the transmit-empty flag goes high. This is the host's cue to write the sample for the other channel. A channel-side output tells which channel the word now shifting belongs to.

If the buffer is still empty when the next word starts, the block enters underrun. It drives the data line low and holds that state until the host clears the enable. After re-enabling, output waits for the next left-channel boundary.

The controller has five states:

- **IDLE**: disabled, data line low.
- **SYNC**: enabled, waiting for a left boundary.
- **RUN**: shifting words.
- **DRAIN**: disabled mid-word, finishing the current word.
- **UNDERRUN**: stalled after a missed sample.

The transitions are:

- IDLE→SYNC on enable.
- SYNC→IDLE on disable.
- SYNC→RUN at a left boundary with the buffer full.
- SYNC→UNDERRUN at a left boundary with the buffer empty.
- RUN→RUN at each boundary with the buffer full.
- RUN→UNDERRUN at a boundary with the buffer empty.
- RUN→DRAIN on disable.
- DRAIN→IDLE once the word has finished.
- UNDERRUN→IDLE on disable.

Top module: `i2s_slave_tx`

## Requirements
- R1: The serial data output changes only in response to a falling bit-clock edge. It changes exactly three system clock cycles after that edge reaches the input pin: two synchroniser stages plus one register.
- R2: While the enable input is high, a host write fills the buffer, and transmit-empty reads 0 on the next cycle. While the enable input is low, writes are ignored and transmit-empty stays 1.
- R3: A word's most significant bit is driven after the first falling bit-clock edge following the rising edge at which a word-select change was seen. The remaining 15 bits follow, most significant first, one per falling edge.
- R4: The transmit-empty output goes to 1 when the buffer contents move into the shift register at the start of a word.
- R5: The channel-side output equals the word-select level captured at the word's boundary: 0 for left, 1 for right. It holds that value for the whole word.
- R6: If the buffer is empty when a word starts, the underrun output goes to 1 and the serial data output stays 0.
- R7: Underrun stays set while enable is high. It clears the cycle after enable goes low. After re-enabling, the first word sent is a left-channel word.
- R8: After enable, nothing is shifted out until a boundary into the left channel (word-select low) arrives, even if the buffer is full. The first rising bit-clock edge after enable is compared against an assumed earlier level of right.
- R9: If enable goes low while a word is being shifted, all 16 bits of that word are still sent. The data line then returns to 0 and no further word is loaded.
- R10: Clearing enable empties the buffer, so transmit-empty reads 1 from the next cycle.
- R11: The interrupt output is 1 in either of two cases: enable, the transmit-empty interrupt enable and transmit-empty are all 1; or the error interrupt enable and underrun are both 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | Bit clock from the external master |
| ws_in | input | 1 | Word select from the external master (0 left, 1 right) |
| enable | input | 1 | Block enable |
| txe_ie | input | 1 | Interrupt enable for transmit-empty |
| err_ie | input | 1 | Interrupt enable for underrun |
| wr_en | input | 1 | Host write strobe for the holding buffer |
| wr_data | input | SAMPLE_W | Sample written by the host |
| sd_out | output | 1 | Serial audio data |
| txe | output | 1 | Holding buffer is empty |
| chan_right | output | 1 | Channel of the word being shifted (1 right) |
| udr | output | 1 | Underrun flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: SAMPLE_W of 16 and SYNC_STAGES of 2. It drives the bit clock with a period of twelve system clocks. This ratio leaves room to test the fixed three-cycle output latency separately from the settled bit value. The 16-bit sample width makes each word end exactly where the next word-select boundary falls. That alignment lets the bench reach:

- the back-to-back loads of a running stream;
- an underrun caused by one skipped write;
- a restart that begins while the right channel is in progress;
- a disable halfway through a word.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_RUN,
        ST_DRAIN,
        ST_UNDERRUN
    } tx_state_e;

endpackage

// File: rtl/i2s_tx_sync.sv
// Brings the master's bit clock and word select into the system clock domain
// and reports single-cycle rise/fall strobes of the synchronised bit clock.
module i2s_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic ws_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic ws_sync
);

    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] ws_pipe;
    logic              sck_last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_pipe <= '0;
                    ws_pipe  <= '1;
                end else begin
                    sck_pipe <= sck_in;
                    ws_pipe  <= ws_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_pipe <= '0;
                    ws_pipe  <= '1;
                end else begin
                    sck_pipe <= {sck_pipe[STAGES-2:0], sck_in};
                    ws_pipe  <= {ws_pipe[STAGES-2:0], ws_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_last <= 1'b0;
        end else begin
            sck_last <= sck_pipe[STAGES-1];
        end
    end

    assign sck_rise = sck_pipe[STAGES-1] & ~sck_last;
    assign sck_fall = ~sck_pipe[STAGES-1] & sck_last;
    assign ws_sync  = ws_pipe[STAGES-1];

endmodule

// File: rtl/i2s_tx_holdbuf.sv
// One-entry holding buffer between the host and the shift register.
module i2s_tx_holdbuf #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             take,
    output logic             full,
    output logic [WIDTH-1:0] data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (flush) begin
            full <= 1'b0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/i2s_tx_shifter.sv
// Parallel-load, MSB-first shift register with a count of bits already driven.
module i2s_tx_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] load_data,
    output logic             msb,
    output logic             bits_done
);

    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [WIDTH-1:0] sreg;
    logic [CNT_W-1:0] sent;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            sent <= '0;
        end else if (load) begin
            sreg <= load_data;
            sent <= CNT_W'(1);
        end else if (shift) begin
            sreg <= {sreg[WIDTH-2:0], 1'b0};
            if (sent < CNT_W'(WIDTH)) begin
                sent <= sent + CNT_W'(1);
            end
        end
    end

    assign msb       = sreg[WIDTH-1];
    assign bits_done = (sent >= CNT_W'(WIDTH));

endmodule

// File: rtl/i2s_tx_ctrl.sv
// Frame controller: follows word select, decides load / shift / underrun.
module i2s_tx_ctrl
    import i2s_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      sck_rise,
    input  logic      sck_fall,
    input  logic      ws_sync,
    input  logic      buf_full,
    input  logic      bits_done,
    output logic      load,
    output logic      shift,
    output logic      chan_right,
    output tx_state_e state
);

    tx_state_e state_nx;
    logic      ws_last;
    logic      boundary;
    logic      tracking;

    assign tracking = (state == ST_SYNC) || (state == ST_RUN) || (state == ST_DRAIN);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions and strobes
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        shift    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (enable) begin
                    state_nx = ST_SYNC;
                end
            end
            ST_SYNC: begin
                if (!enable) begin
                    state_nx = ST_IDLE;
                end else if (sck_fall && boundary && !ws_last) begin
                    if (buf_full) begin
                        load     = 1'b1;
                        state_nx = ST_RUN;
                    end else begin
                        state_nx = ST_UNDERRUN;
                    end
                end
            end
            ST_RUN: begin
                if (sck_fall) begin
                    if (boundary) begin
                        if (buf_full) begin
                            load = 1'b1;
                        end else begin
                            state_nx = enable ? ST_UNDERRUN : ST_IDLE;
                        end
                    end else begin
                        shift = 1'b1;
                    end
                end
                if (!enable && state_nx == ST_RUN) begin
                    state_nx = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (sck_fall) begin
                    if (boundary || bits_done) begin
                        state_nx = ST_IDLE;
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
            ST_UNDERRUN: begin
                if (!enable) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Word-select tracking and channel side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_last    <= 1'b1;
            boundary   <= 1'b0;
            chan_right <= 1'b0;
        end else begin
            if (state == ST_IDLE && enable) begin
                ws_last  <= 1'b1;
                boundary <= 1'b0;
            end else if (tracking) begin
                if (sck_rise) begin
                    boundary <= (ws_sync != ws_last);
                    ws_last  <= ws_sync;
                end else if (sck_fall) begin
                    boundary <= 1'b0;
                end
            end
            if (load) begin
                chan_right <= ws_last;
            end
        end
    end

endmodule

// File: rtl/i2s_slave_tx.sv
module i2s_slave_tx
    import i2s_tx_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck_in,
    input  logic                ws_in,
    input  logic                enable,
    input  logic                txe_ie,
    input  logic                err_ie,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_data,
    output logic                sd_out,
    output logic                txe,
    output logic                chan_right,
    output logic                udr,
    output logic                irq
);

    logic                sck_rise;
    logic                sck_fall;
    logic                ws_sync;
    logic                buf_full;
    logic [SAMPLE_W-1:0] buf_data;
    logic                load;
    logic                shift;
    logic                sh_msb;
    logic                bits_done;
    tx_state_e           state;

    i2s_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (sck_in),
        .ws_in    (ws_in),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .ws_sync  (ws_sync)
    );

    i2s_tx_holdbuf #(.WIDTH(SAMPLE_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (!enable),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load),
        .full    (buf_full),
        .data    (buf_data)
    );

    i2s_tx_shifter #(.WIDTH(SAMPLE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .shift     (shift),
        .load_data (buf_data),
        .msb       (sh_msb),
        .bits_done (bits_done)
    );

    i2s_tx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .ws_sync    (ws_sync),
        .buf_full   (buf_full),
        .bits_done  (bits_done),
        .load       (load),
        .shift      (shift),
        .chan_right (chan_right),
        .state      (state)
    );

    // Output decode
    always_comb begin
        sd_out = ((state == ST_RUN) || (state == ST_DRAIN)) ? sh_msb : 1'b0;
        txe    = !buf_full;
        udr    = (state == ST_UNDERRUN);
        irq    = (enable && txe_ie && !buf_full) || (err_ie && (state == ST_UNDERRUN));
    end

endmodule

// File: rtl/i2s_slave_tx_chk.sv
module i2s_slave_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic txe_ie,
    input logic err_ie,
    input logic wr_en,
    input logic sck_fall,
    input logic sd_out,
    input logic txe,
    input logic udr,
    input logic irq
);

    p_sd_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_out) |-> $past(sck_fall));

    p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr_en) |=> !txe);

    p_udr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        udr |-> !sd_out);

    p_udr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (udr && enable) |=> udr);

    p_udr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !udr);

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> txe);

    p_err_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ie && udr) |-> irq);

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!txe_ie && !err_ie) |-> !irq);

endmodule

bind i2s_slave_tx i2s_slave_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .txe_ie   (txe_ie),
    .err_ie   (err_ie),
    .wr_en    (wr_en),
    .sck_fall (sck_fall),
    .sd_out   (sd_out),
    .txe      (txe),
    .udr      (udr),
    .irq      (irq)
);

// File: tb/i2s_slave_tx_test.sv
module i2s_slave_tx_test;

    localparam int H = 6;  // system clocks per bit-clock half period

    localparam int M_IDLE  = 0;
    localparam int M_SYNC  = 1;
    localparam int M_RUN   = 2;
    localparam int M_DRAIN = 3;
    localparam int M_UDR   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck_in = 1'b1;
    logic        ws_in = 1'b1;
    logic        enable = 1'b0;
    logic        txe_ie = 1'b1;
    logic        err_ie = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        sd_out, txe, chan_right, udr, irq;

    always #2 clk = ~clk;

    i2s_slave_tx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_in     (sck_in),
        .ws_in      (ws_in),
        .enable     (enable),
        .txe_ie     (txe_ie),
        .err_ie     (err_ie),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .sd_out     (sd_out),
        .txe        (txe),
        .chan_right (chan_right),
        .udr        (udr),
        .irq        (irq)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int          m_mode = M_IDLE;
    logic        m_prev = 1'b1;
    logic        m_pend = 1'b0;
    logic        m_full = 1'b0;
    logic [15:0] m_buf = 16'h0;
    logic [15:0] m_sh = 16'h0;
    int          m_bits = 0;
    logic        m_chan = 1'b0;
    logic        m_loaded = 1'b0;

    int          gslot = 24;
    int          cmd = 0;
    logic        autowrite = 1'b0;
    logic        skip_writes = 1'b0;
    logic        watch_restart = 1'b0;
    logic [15:0] next_sample = 16'hA5C3;

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic m_sd();
        return ((m_mode == M_RUN) || (m_mode == M_DRAIN)) ? m_sh[15] : 1'b0;
    endfunction

    function automatic logic m_irq();
        return (enable && txe_ie && !m_full) || (err_ie && (m_mode == M_UDR));
    endfunction

    task automatic take_word();
        if (m_full) begin
            m_sh     = m_buf;
            m_full   = 1'b0;
            m_bits   = 1;
            m_chan   = m_prev;
            m_mode   = M_RUN;
            m_loaded = 1'b1;
        end else begin
            m_mode = M_UDR;
        end
    endtask

    task automatic model_fall();
        m_loaded = 1'b0;
        if (m_mode == M_RUN || m_mode == M_DRAIN) begin
            if (m_mode == M_DRAIN && (m_pend || m_bits >= 16)) begin
                m_mode = M_IDLE;
            end else if (m_mode == M_RUN && m_pend) begin
                take_word();
            end else begin
                m_sh = {m_sh[14:0], 1'b0};
                if (m_bits < 16) m_bits++;
            end
            m_pend = 1'b0;
        end else if (m_mode == M_SYNC) begin
            if (m_pend && !m_prev) take_word();
            m_pend = 1'b0;
        end
    endtask

    task automatic model_rise(input logic w);
        if (m_mode == M_SYNC || m_mode == M_RUN || m_mode == M_DRAIN) begin
            m_pend = (w != m_prev);
            m_prev = w;
        end
    endtask

    // One full bit-clock period: falling edge first, then rising edge.
    task automatic one_cycle();
        logic ws_v;
        logic sd_before;
        string sd_req;
        ws_v = ((gslot / 16) % 2) == 1;
        gslot++;
        sd_before = m_sd();
        sck_in = 1'b0;
        ws_in  = ws_v;
        model_fall();
        repeat (2) @(negedge clk);
        check("R1", "sd before latency", sd_out, sd_before);
        @(negedge clk);
        check("R1", "sd after latency", sd_out, m_sd());
        repeat (H - 3) @(negedge clk);
        sd_req = (m_mode == M_DRAIN) ? "R9" : (m_mode == M_SYNC) ? "R8" :
                 (m_mode == M_UDR) ? "R6" : "R3";
        check(sd_req, "sd", sd_out, m_sd());
        check(enable ? "R4" : "R10", "txe", txe, !m_full);
        check("R6", "udr", udr, m_mode == M_UDR);
        check("R5", "chan_right", chan_right, m_chan);
        check("R11", "irq", irq, m_irq());
        if (watch_restart && m_loaded) begin
            check("R7", "first word after restart is left", chan_right, 1'b0);
            watch_restart = 1'b0;
        end
        // host phase, together with the rising edge
        sck_in = 1'b1;
        if (cmd == 1) begin
            enable = 1'b1;
            if (m_mode == M_IDLE) begin
                m_mode = M_SYNC;
                m_prev = 1'b1;
                m_pend = 1'b0;
            end
        end else if (cmd == 2) begin
            enable = 1'b0;
            m_full = 1'b0;
            if (m_mode == M_SYNC || m_mode == M_UDR) m_mode = M_IDLE;
            else if (m_mode == M_RUN) m_mode = M_DRAIN;
        end
        cmd = 0;
        if (autowrite && enable && !skip_writes && !m_full &&
            (m_mode == M_SYNC || m_mode == M_RUN)) begin
            wr_en   = 1'b1;
            wr_data = next_sample;
            m_full  = 1'b1;
            m_buf   = next_sample;
            next_sample = {next_sample[14:0], next_sample[15] ^ next_sample[13]} + 16'h0101;
        end
        @(negedge clk);
        wr_en = 1'b0;
        model_rise(ws_v);
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) one_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6", "reset sd", sd_out, 1'b0);
        check("R10", "reset txe", txe, 1'b1);
        check("R6", "reset udr", udr, 1'b0);
        check("R5", "reset chan", chan_right, 1'b0);
        check("R11", "reset irq", irq, 1'b0);

        // R2: a write while disabled is ignored
        wr_en = 1'b1; wr_data = 16'h1234;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R2", "write while disabled", txe, 1'b1);

        // R8/R3/R4: enable, first left sample, steady stream
        autowrite = 1'b1;
        cmd = 1;
        one_cycle();
        check("R2", "write while enabled", txe, 1'b0);
        run(8 + 32 * 3);

        // R6: a missed write causes underrun
        skip_writes = 1'b1;
        for (int i = 0; i < 60 && m_mode != M_UDR; i++) one_cycle();
        skip_writes = 1'b0;
        check("R6", "underrun reached", udr, 1'b1);
        run(6);
        txe_ie = 1'b0; err_ie = 1'b0;
        run(3);
        txe_ie = 1'b1; err_ie = 1'b1;
        run(3);
        check("R7", "underrun held while enabled", udr, 1'b1);

        // R7/R10: disable clears underrun and empties the buffer
        cmd = 2;
        one_cycle();
        check("R7", "underrun cleared", udr, 1'b0);
        check("R10", "buffer flushed", txe, 1'b1);
        wr_en = 1'b1; wr_data = 16'h5555;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R2", "write ignored while disabled", txe, 1'b1);
        run(5);

        // R7/R8: restart in the middle of a right-channel word
        while (!(((gslot / 16) % 2) == 1 && (gslot % 16) == 4)) one_cycle();
        cmd = 1;
        watch_restart = 1'b1;
        run(64 + 12);

        // R9: disable halfway through a word
        for (int i = 0; i < 40 && !(m_mode == M_RUN && m_bits == 8); i++) one_cycle();
        cmd = 2;
        run(30);
        check("R9", "line idle after drain", sd_out, 1'b0);

        finish_sim();
    end

endmodule